// File: doc/BRIEF.md
# SHA-256 Two-Round Compression Step

This block advances a SHA-256 working state by exactly two compression rounds. The eight working words are split over two 128-bit operands. The lower-order operand `cdgh_i` carries C, D, G and H. The higher-order operand `abef_i` carries A, B, E and F. A third 128-bit operand, `wk_i`, supplies the message word already summed with its round constant, one 32-bit lane per round.

One round is applied on each clock. When the two rounds are finished, the new A, B, E and F are packed into a result register. The surrounding datapath issues the step twice per group of four rounds. It keeps the C, D, G and H half on its own side, because those values equal the previous A, B, E and F.

Operation is controlled by a start/busy/done handshake. The unit captures all three operands on the accepted start edge, so they need not be held afterwards.

Top module: `sha2_dual_round`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy_o` and `done_o` are 0 and `result_o` is all zeros until the first completion.
- R2: On an accepted start, A, B, E and F are taken from bits [127:96], [95:64], [63:32] and [31:0] of `abef_i`. C, D, G and H are taken from the same bit ranges of `cdgh_i`.
- R3: Each round computes T = Ch(E,F,G) + S1(E) + WK + H, where Ch = (E&F)^(~E&G) and S1 = ror6^ror11^ror25 of E.
- R4: Each round then sets the new A to T + Maj(A,B,C) + S0(A), where Maj = (A&B)^(A&C)^(B&C) and S0 = ror2^ror13^ror22 of A. It sets the new E to T + D, and shifts the rest: B from A, C from B, D from C, F from E, G from F, H from G.
- R5: The first round uses `wk_i[31:0]` and the second round uses `wk_i[63:32]`. Bits [127:64] of `wk_i` have no effect on the result.
- R6: All additions wrap modulo 2^32.
- R7: After the two rounds, `result_o` holds A in [127:96], B in [95:64], E in [63:32] and F in [31:0].
- R8: A start is accepted only when `busy_o` is 0. After an accepted start, `busy_o` is 1 for exactly two cycles. `done_o` is 1 for exactly one cycle, in the cycle in which `result_o` first shows the new value.
- R9: A start raised while `busy_o` is 1 is ignored: it produces no extra completion and does not change the result.
- R10: Operand inputs are sampled only on the accepted start edge. `result_o` keeps its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| cdgh_i | input | 128 | Working words C, D, G, H (high lane to low lane) |
| abef_i | input | 128 | Working words A, B, E, F (high lane to low lane) |
| wk_i | input | 128 | Pre-summed message plus constant; lanes 0 and 1 used |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse, result newly valid |
| result_o | output | 128 | New A, B, E, F (high lane to low lane) |

## Verification
Start is taken on clock edge 0, and the two rounds run on edges 1 and 2. The result register and `done_o` therefore change on edge 2, and `done_o` falls on edge 3.

The bench drives stimulus on falling edges and samples one half-period after each of those edges:
- `busy_o` is checked after edge 0 and after edge 1.
- `done_o` and the result are checked after edge 2.
- The fall of `done_o` is checked after edge 3.

A scoreboard queue holds one expected word per accepted start, computed by a separate reference model. A monitor pops and compares an entry on every sampled `done_o`. Any unexpected or missing completion therefore shows up as a mismatch or as a non-empty queue at the end.

// File: rtl/sha2_rnd_pkg.sv
// Package: shared widths, the working-state type and the SHA-256 bit
// functions used by the round logic. Assumes 32-bit words, 4 lanes per operand.
package sha2_rnd_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = 4;
    localparam int VEC_W   = WORD_W * LANES;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } work_t;

    function automatic word_t rotr(input word_t v, input int unsigned n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction

    function automatic word_t f_choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t f_major(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic word_t f_sum_a(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t f_sum_e(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

endpackage

// File: rtl/sha2_round_core.sv
// Module: one combinational SHA-256 round. Takes the current working
// state and one pre-summed W+K word, returns the next working state.
// Assumes the caller registers the output; no internal state.
module sha2_round_core
    import sha2_rnd_pkg::*;
(
    input  work_t cur_i,
    input  word_t wk_i,
    output work_t nxt_o
);

    word_t t_sum;
    word_t a_sum;

    // Round temporaries: shared term T and the new A value
    always_comb begin
        t_sum = f_choose(cur_i.e, cur_i.f, cur_i.g) + f_sum_e(cur_i.e)
              + wk_i + cur_i.h;
        a_sum = t_sum + f_major(cur_i.a, cur_i.b, cur_i.c) + f_sum_a(cur_i.a);
    end

    // Next state: new A/E plus the shift of the remaining words
    always_comb begin
        nxt_o.a = a_sum;
        nxt_o.b = cur_i.a;
        nxt_o.c = cur_i.b;
        nxt_o.d = cur_i.c;
        nxt_o.e = t_sum + cur_i.d;
        nxt_o.f = cur_i.e;
        nxt_o.g = cur_i.f;
        nxt_o.h = cur_i.g;
    end

endmodule

// File: rtl/sha2_seq_ctrl.sv
// Module: sequencer for the round unit. Accepts start when idle, counts
// ROUNDS steps, flags the last step and pulses done after it.
// Assumes ROUNDS >= 1; synchronous active-low reset.
module sha2_seq_ctrl #(
    parameter int ROUNDS = 2,
    localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             load_o,
    output logic             step_o,
    output logic             last_o,
    output logic [CNT_W-1:0] rnd_o,
    output logic             busy_o,
    output logic             done_o
);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] rnd_q;

    // Decode the control strobes from the current state
    always_comb begin
        load_o = start_i && !busy_q;
        step_o = busy_q;
        last_o = busy_q && (rnd_q == CNT_W'(ROUNDS - 1));
    end

    // Busy flag, round counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rnd_q  <= '0;
        end else begin
            done_q <= last_o;
            if (load_o) begin
                busy_q <= 1'b1;
                rnd_q  <= '0;
            end else if (last_o) begin
                busy_q <= 1'b0;
                rnd_q  <= '0;
            end else if (busy_q) begin
                rnd_q  <= rnd_q + 1'b1;
            end
        end
    end

    assign rnd_o  = rnd_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

endmodule

// File: rtl/sha2_dual_round.sv
// Module: top of the two-round SHA-256 step. Unpacks the split operands
// into a working state, runs one round per clock and packs A,B,E,F into
// the result register. Assumes ROUNDS <= LANES of the WK operand.
module sha2_dual_round
    import sha2_rnd_pkg::*;
#(
    parameter int ROUNDS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VEC_W-1:0] cdgh_i,
    input  logic [VEC_W-1:0] abef_i,
    input  logic [VEC_W-1:0] wk_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [VEC_W-1:0] result_o
);

    localparam int CNT_W  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam int WK_W   = ROUNDS * WORD_W;

    logic             load;
    logic             step;
    logic             last;
    logic [CNT_W-1:0] rnd;

    work_t            work_q;
    work_t            work_nxt;
    work_t            work_init;
    logic [WK_W-1:0]  wk_q;
    word_t            wk_lane [ROUNDS];
    word_t            wk_cur;
    logic [VEC_W-1:0] result_q;
    logic [VEC_W-WK_W-1:0] unused_wk_hi;

    assign unused_wk_hi = wk_i[VEC_W-1:WK_W];

    sha2_seq_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .load_o (load),
        .step_o (step),
        .last_o (last),
        .rnd_o  (rnd),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    // Split the captured WK vector into one word per round
    for (genvar r = 0; r < ROUNDS; r++) begin : g_wk_lane
        assign wk_lane[r] = wk_q[r*WORD_W +: WORD_W];
    end

    // Select the WK word for the round in progress
    always_comb begin
        wk_cur = wk_lane[rnd];
    end

    // Map the two packed operands onto the working-state fields
    always_comb begin
        work_init.a = abef_i[4*WORD_W-1:3*WORD_W];
        work_init.b = abef_i[3*WORD_W-1:2*WORD_W];
        work_init.e = abef_i[2*WORD_W-1:1*WORD_W];
        work_init.f = abef_i[1*WORD_W-1:0];
        work_init.c = cdgh_i[4*WORD_W-1:3*WORD_W];
        work_init.d = cdgh_i[3*WORD_W-1:2*WORD_W];
        work_init.g = cdgh_i[2*WORD_W-1:1*WORD_W];
        work_init.h = cdgh_i[1*WORD_W-1:0];
    end

    sha2_round_core u_round (
        .cur_i(work_q),
        .wk_i (wk_cur),
        .nxt_o(work_nxt)
    );

    // Working state and WK capture: load on start, advance per round
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            wk_q   <= '0;
        end else if (load) begin
            work_q <= work_init;
            wk_q   <= wk_i[WK_W-1:0];
        end else if (step) begin
            work_q <= work_nxt;
        end
    end

    // Result register: pack A,B,E,F after the final round
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (last) begin
            result_q <= {work_nxt.a, work_nxt.b, work_nxt.e, work_nxt.f};
        end
    end

    assign result_o = result_q;

endmodule

// File: rtl/sha2_dual_round_chk.sv
// Module: protocol checker for sha2_dual_round, attached with bind.
// Assumes ROUNDS = 2 (busy window of two cycles).
module sha2_dual_round_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [127:0] result_o
);

    // R8
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |=> busy_o);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ##1 !busy_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

endmodule

bind sha2_dual_round sha2_dual_round_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .result_o(result_o)
);

// File: tb/sha2_dual_round_bench.sv
`timescale 1ns/1ps
module sha2_dual_round_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] cdgh_i = '0;
    logic [127:0] abef_i = '0;
    logic [127:0] wk_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [127:0] result_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [127:0] expq[$];
    logic [127:0] last_exp = '0;

    always #10 clk = ~clk;

    sha2_dual_round u_sha2_dual_round (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cdgh_i(cdgh_i), .abef_i(abef_i), .wk_i(wk_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements
    function automatic logic [127:0] ref_two(input logic [127:0] x,
                                             input logic [127:0] y,
                                             input logic [127:0] wk);
        logic [31:0] a, b, c, d, e, f, g, h, t, s0, s1, ch, mj, w;
        a = y[127:96]; b = y[95:64]; e = y[63:32]; f = y[31:0];
        c = x[127:96]; d = x[95:64]; g = x[63:32]; h = x[31:0];
        for (int r = 0; r < 2; r++) begin
            w  = (r == 0) ? wk[31:0] : wk[63:32];
            s1 = {e[5:0], e[31:6]} ^ {e[10:0], e[31:11]} ^ {e[24:0], e[31:25]};
            s0 = {a[1:0], a[31:2]} ^ {a[12:0], a[31:13]} ^ {a[21:0], a[31:22]};
            ch = (e & f) | (~e & g);
            mj = (a & b) | (a & c) | (b & c);
            t  = h + s1 + ch + w;
            h = g; g = f; f = e; e = d + t;
            d = c; c = b; b = a; a = t + s0 + mj;
        end
        return {a, b, e, f};
    endfunction

    // Driver: one accepted start; mode 1 scrambles inputs, mode 2 adds an ignored start
    task automatic run_op(input logic [127:0] x, input logic [127:0] y,
                          input logic [127:0] wk, input int mode, input string req);
        logic [127:0] e;
        e = ref_two(x, y, wk);
        expq.push_back(e);
        last_exp = e;
        cdgh_i = x; abef_i = y; wk_i = wk; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1 && done_o == 1'b0, "R8 busy after start",
              {126'd0, busy_o, done_o}, 128'd2);
        if (mode >= 1) begin
            cdgh_i = {4{$urandom}}; abef_i = {4{$urandom}}; wk_i = {4{$urandom}};
        end
        if (mode == 2) start_i = 1'b1;   // R9 start while busy
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1 && done_o == 1'b0, "R8 busy second cycle",
              {126'd0, busy_o, done_o}, 128'd2);
        if (mode >= 1) begin
            cdgh_i = ~x; abef_i = ~y; wk_i = ~wk;  // R10 not resampled
        end
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b1, {req, " R8 done slot"},
              {126'd0, busy_o, done_o}, 128'd1);
        @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, "R8 R9 done one cycle, no restart",
              {126'd0, busy_o, done_o}, 128'd0);
    endtask

    // Monitor: compare each completion with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 unexpected completion", result_o, '0);
            end else begin
                logic [127:0] e;
                e = expq.pop_front();
                check(result_o === e, "R2 R3 R4 R7 result", result_o, e);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [127:0] ra, rb;
        repeat (3) @(negedge clk);
        // R1 reset state while reset held
        check(busy_o == 0 && done_o == 0 && result_o == '0, "R1 reset",
              result_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 0 && done_o == 0 && result_o == '0, "R1 after release",
              result_o, '0);

        // R2 R7 lane mapping with distinct lane patterns
        run_op(128'h11111111_22222222_33333333_44444444,
               128'h55555555_66666666_77777777_88888888,
               128'h0_0_00000002_00000001, 0, "R2 R7 lanes");
        // R3 R4 typical working values
        run_op(128'ha54ff53a_3c6ef372_1f83d9ab_5be0cd19,
               128'h6a09e667_bb67ae85_510e527f_9b05688c,
               128'h12345678_9abcdef0_71374491_428a2f98, 0, "R3 R4 rounds");
        // R6 wraparound with all ones
        run_op({128{1'b1}}, {128{1'b1}}, {128{1'b1}}, 0, "R6 wrap");
        // R4 zero state, only WK drives
        run_op('0, '0, 128'h0_0_80000000_00000001, 0, "R4 zero state");

        // R5 upper WK lanes ignored: same result for two different upper halves
        ra = ref_two(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
                     128'hdead_beef_cafe_f00d_0bad_f00d_1234_abcd,
                     128'h00000000_00000000_b5c0fbcf_e9b5dba5);
        run_op(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
               128'hdead_beef_cafe_f00d_0bad_f00d_1234_abcd,
               128'hffffffff_aaaaaaaa_b5c0fbcf_e9b5dba5, 0, "R5 upper lanes");
        rb = result_o;
        check(rb === ra, "R5 upper WK lanes no effect", rb, ra);

        // R10 inputs changed while busy do not matter
        run_op(128'hcafebabe_00ff00ff_f0f0f0f0_13579bdf,
               128'h2468ace0_0f0f0f0f_ff00ff00_deadc0de,
               128'h0_0_3956c25b_59f111f1, 1, "R10 hold inputs");
        // R9 start during busy is ignored
        run_op(128'h1_2_3_4, 128'h5_6_7_8, 128'h0_0_9_a, 2, "R9 busy start");

        // R10 result holds while idle
        repeat (5) @(negedge clk);
        check(result_o === last_exp && busy_o == 0, "R10 result hold",
              result_o, last_exp);

        // Back-to-back operations
        for (int k = 0; k < 4; k++) begin
            run_op({4{$urandom}}, {4{$urandom}}, {4{$urandom}}, 0, "R4 random");
        end

        check(expq.size() == 0, "R9 scoreboard drained",
              128'(expq.size()), 128'd0);
        finish_run();
    end

endmodule